// File: doc/BRIEF.md
# Embedded Controller Host Port Responder

This block sits on the controller side of a two-port host I/O window. Through it, a host reaches a 256-byte register space that belongs to an embedded controller. One port carries data bytes. The other port returns status when the host reads it and accepts command bytes when the host writes it. Every byte the host writes is latched, and the input-busy flag stays high for a fixed number of cycles. The byte is acted on in the cycle that flag drops.

The host follows a strict protocol. Before each write it polls until the input-busy flag is low, and before each data read it polls until the output-ready flag is high. A register read is a read command, then an address byte, then a read of the result. A register write is a write command, an address byte and a value byte. Two other commands switch a burst indicator on and off. A query command returns an empty event code. Toward the controller the block presents a plain register strobe interface, with the read data sampled in the strobe cycle.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00 and neither register strobe is asserted.
- R2: Address 0 is the data port and address 4 is the status/command port. Any other address reads 0x00, and a write to it leaves the input-busy flag low and has no other effect.
- R3: An accepted host write to either port raises input-busy (status bit 1) at the write edge. The flag stays high for exactly IBF_HOLD cycles, and the byte takes effect at the edge where the flag drops.
- R4: Status bit 3 is set by a write to the command port and cleared by a write to the data port.
- R5: Command 0x80 followed by an address byte issues one register read strobe at that address. The returned value is loaded into the output buffer and output-ready (status bit 0) is set.
- R6: Command 0x81 followed by an address byte and a value byte issues one register write strobe carrying that address and value.
- R7: A host read of the data port clears output-ready. A read of the status port does not clear it.
- R8: A data-port byte that arrives with no command in progress causes no strobe and leaves output-ready unchanged.
- R9: A command byte other than 0x80 to 0x84 returns the sequencer to idle, so the data bytes that follow are ignored.
- R10: Command 0x82 sets the burst flag (status bit 4). Only command 0x83 clears it.
- R11: Command 0x84 loads 0x00 into the output buffer and sets output-ready.
- R12: A host write that arrives while input-busy is high is dropped.
- R13: A command byte that arrives in the middle of a sequence abandons that sequence and starts the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status or output buffer, selected by address |
| reg_addr | output | 8 | Controller register address |
| reg_wdata | output | 8 | Controller register write value |
| reg_we | output | 1 | Controller register write strobe |
| reg_re | output | 1 | Controller register read strobe |
| reg_rdata | input | 8 | Controller register value, sampled in the reg_re cycle |

## Verification
Two faults show up quickly at the ports. If the busy counter is off, the input-busy flag is high for the wrong number of cycles. That error appears on the status byte within one hold window of the first write. If the sequencer is left in the wrong state, the error shows on the next data byte: either a strobe appears where none belongs, or a strobe carries the wrong address, or output-ready fails to rise. A burst flag or command-marker bit that is held wrongly shows up at the next status read.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;

    localparam logic [7:0] OP_RD        = 8'h80;
    localparam logic [7:0] OP_WR        = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;
    localparam logic [7:0] EVT_NONE     = 8'h00;

    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } seq_state_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] data;
    } host_byte_t;

    function automatic logic [7:0] pack_status(input logic obf, input logic ibf,
                                               input logic cmd, input logic burst);
        logic [7:0] s;
        s           = 8'h00;
        s[ST_OBF]   = obf;
        s[ST_IBF]   = ibf;
        s[ST_CMD]   = cmd;
        s[ST_BURST] = burst;
        return s;
    endfunction

endpackage

// File: rtl/ec_in_latch.sv
module ec_in_latch
    import ec_port_pkg::*;
#(
    parameter int IBF_HOLD = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  host_byte_t in_byte,
    output logic       ibf,
    output logic       take,
    output logic       cmd_flag,
    output host_byte_t held
);
    localparam int CW = $clog2(IBF_HOLD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf      <= 1'b0;
            cnt      <= '0;
            held     <= '0;
            cmd_flag <= 1'b0;
        end else if (accept) begin
            ibf      <= 1'b1;
            cnt      <= CW'(IBF_HOLD);
            held     <= in_byte;
            cmd_flag <= in_byte.is_cmd;
        end else if (ibf) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) ibf <= 1'b0;
        end
    end

    assign take = ibf && (cnt == CW'(1));

    AST_IBF_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(ibf) |-> $past(take)); // R3

    AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        accept |-> !ibf); // R12

endmodule

// File: rtl/ec_seq.sv
module ec_seq
    import ec_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  host_byte_t held,
    input  logic [7:0] reg_rdata,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    output logic       load_obf,
    output logic [7:0] load_val,
    output logic       burst
);
    seq_state_e state, state_n;
    logic [7:0] addr_q;
    logic       burst_n;

    always_comb begin
        state_n   = state;
        burst_n   = burst;
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        load_obf  = 1'b0;
        load_val  = EVT_NONE;
        reg_addr  = addr_q;
        reg_wdata = held.data;
        if (take) begin
            if (held.is_cmd) begin
                state_n = SQ_IDLE;
                case (held.data)
                    OP_RD:        state_n = SQ_RD_ADDR;
                    OP_WR:        state_n = SQ_WR_ADDR;
                    OP_BURST_ON:  burst_n = 1'b1;
                    OP_BURST_OFF: burst_n = 1'b0;
                    OP_QUERY: begin
                        load_obf = 1'b1;
                        load_val = EVT_NONE;
                    end
                    default:      state_n = SQ_IDLE;
                endcase
            end else begin
                case (state)
                    SQ_RD_ADDR: begin
                        reg_addr = held.data;
                        reg_re   = 1'b1;
                        load_obf = 1'b1;
                        load_val = reg_rdata;
                        state_n  = SQ_IDLE;
                    end
                    SQ_WR_ADDR: state_n = SQ_WR_DATA;
                    SQ_WR_DATA: begin
                        reg_we  = 1'b1;
                        state_n = SQ_IDLE;
                    end
                    default:    state_n = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            addr_q <= 8'h00;
            burst  <= 1'b0;
        end else begin
            state <= state_n;
            burst <= burst_n;
            if (take && !held.is_cmd && state == SQ_WR_ADDR) addr_q <= held.data;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re)); // R6

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(burst)); // R10

    AST_IDLE_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        (take && !held.is_cmd && state == SQ_IDLE) |-> !(reg_we || reg_re || load_obf)); // R8

endmodule

// File: rtl/ec_out_buf.sv
module ec_out_buf (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       drain,
    output logic       obf,
    output logic [7:0] obuf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            obf  <= 1'b0;
            obuf <= 8'h00;
        end else if (load) begin
            obf  <= 1'b1;
            obuf <= load_val;
        end else if (drain) begin
            obf <= 1'b0;
        end
    end

    AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (rst)
        load |=> (obf && obuf == $past(load_val))); // R5

    AST_IDLE_KEEPS_OBF: assert property (@(posedge clk) disable iff (rst)
        (!load && !drain) |=> $stable(obf)); // R7

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_port_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 0,
    parameter int CTRL_OFS = 4,
    parameter int IBF_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [7:0]        reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [7:0]        reg_rdata
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

    logic       sel_data, sel_ctrl, accept, drain;
    logic       ibf, take, cmd_flag, burst, obf, load_obf;
    logic [7:0] obuf, load_val;
    host_byte_t in_byte, held;

    assign sel_data = (host_addr == A_DATA);
    assign sel_ctrl = (host_addr == A_CTRL);
    assign accept   = host_wr && (sel_data || sel_ctrl) && !ibf;
    assign drain    = host_rd && sel_data;
    assign in_byte  = '{is_cmd: sel_ctrl, data: host_wdata};

    ec_in_latch #(.IBF_HOLD(IBF_HOLD)) u_latch (
        .clk(clk), .rst(rst), .accept(accept), .in_byte(in_byte),
        .ibf(ibf), .take(take), .cmd_flag(cmd_flag), .held(held)
    );

    ec_seq u_seq (
        .clk(clk), .rst(rst), .take(take), .held(held), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .load_obf(load_obf), .load_val(load_val), .burst(burst)
    );

    ec_out_buf u_obuf (
        .clk(clk), .rst(rst), .load(load_obf), .load_val(load_val), .drain(drain),
        .obf(obf), .obuf(obuf)
    );

    always_comb begin
        if (sel_ctrl)      host_rdata = pack_status(obf, ibf, cmd_flag, burst);
        else if (sel_data) host_rdata = obuf;
        else               host_rdata = 8'h00;
    end

    AST_WRITE_SETS_IBF: assert property (@(posedge clk) disable iff (rst)
        (host_wr && (sel_data || sel_ctrl) && !ibf) |=> ibf); // R3

    AST_STRAY_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !sel_data && !sel_ctrl && !ibf) |=> !ibf); // R2

    AST_READ_FILLS_OBF: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> obf); // R5

endmodule

// File: tb/sim_ec_host_port.sv
`timescale 1ns/1ps
module sim_ec_host_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = 3'd0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata, reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic [7:0] mem [0:255];
    int checks = 0, fails = 0, re_cnt = 0, we_cnt = 0;
    logic [7:0] last_re_addr, last_we_addr, last_we_data;
    localparam int HOLD = 4;

    always #2 clk = ~clk;

    ec_host_port #(.ADDR_W(3), .DATA_OFS(0), .CTRL_OFS(4), .IBF_HOLD(HOLD)) u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
                last_we_addr <= reg_addr;
                last_we_data <= reg_wdata;
            end
            if (reg_re) begin
                re_cnt <= re_cnt + 1;
                last_re_addr <= reg_addr;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] s);
        host_addr = 3'd4;
        #1 s = host_rdata;
    endtask

    task automatic wait_ibf();
        logic [7:0] s;
        peek(s);
        while (s[1]) begin @(negedge clk); peek(s); end
        @(negedge clk);
    endtask

    task automatic wait_obf();
        logic [7:0] s;
        peek(s);
        while (!s[0]) begin @(negedge clk); peek(s); end
        @(negedge clk);
    endtask

    task automatic ec_wr(input logic [7:0] a, input logic [7:0] d);
        wait_ibf(); hwr(3'd4, 8'h81);
        wait_ibf(); hwr(3'd0, a);
        wait_ibf(); hwr(3'd0, d);
        wait_ibf();
    endtask

    task automatic ec_rd(input logic [7:0] a, output logic [7:0] d);
        wait_ibf(); hwr(3'd4, 8'h80);
        wait_ibf(); hwr(3'd0, a);
        wait_obf(); hrd(3'd0, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(v);
        chk("R1 status", v, 8'h00);
        hrd(3'd0, v);
        chk("R1 data", v, 8'h00);
        chk("R1 strobes", re_cnt + we_cnt, 0);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        hrd(3'd2, v);
        chk("R2 stray read", v, 8'h00);
        hwr(3'd2, 8'h80);
        peek(v);
        chk("R2 stray write no ibf", v, 8'h00);
    endtask

    task automatic t_ibf();
        logic [7:0] s;
        int n = 0;
        int we0 = we_cnt;
        wait_ibf(); hwr(3'd4, 8'h81);
        peek(s);
        chk("R4 cmd bit set", s[3], 1);
        wait_ibf(); hwr(3'd0, 8'h10);
        peek(s);
        chk("R4 cmd bit clear", s[3], 0);
        wait_ibf(); hwr(3'd0, 8'hC3);
        peek(s);
        while (s[1] && n < 50) begin
            n++;
            chk("R3 no early effect", we_cnt, we0);
            @(negedge clk); peek(s);
        end
        chk("R3 ibf width", n, HOLD);
        chk("R3 acted at clear", we_cnt, we0 + 1);
    endtask

    task automatic t_write();
        int w0 = we_cnt;
        ec_wr(8'h42, 8'hA7);
        chk("R6 one strobe", we_cnt, w0 + 1);
        chk("R6 addr", last_we_addr, 8'h42);
        chk("R6 data", last_we_data, 8'hA7);
        chk("R6 mem", mem[8'h42], 8'hA7);
    endtask

    task automatic t_read();
        logic [7:0] v, s;
        int r0 = re_cnt;
        ec_rd(8'h42, v);
        chk("R5 value", v, 8'hA7);
        chk("R5 one strobe", re_cnt, r0 + 1);
        chk("R5 addr", last_re_addr, 8'h42);
        ec_rd(8'hF0, v);
        chk("R5 value 2", v, 8'hF0 ^ 8'h5A);
        peek(s);
        chk("R7 obf cleared by data read", s[0], 0);
    endtask

    task automatic t_status_keeps_obf();
        logic [7:0] s;
        wait_ibf(); hwr(3'd4, 8'h80);
        wait_ibf(); hwr(3'd0, 8'h01);
        wait_obf();
        hrd(3'd4, s); hrd(3'd4, s);
        peek(s);
        chk("R7 status read keeps obf", s[0], 1);
        hrd(3'd0, s);
        chk("R7 data", s, 8'h01 ^ 8'h5A);
    endtask

    task automatic t_orphan();
        logic [7:0] s;
        int c0 = re_cnt + we_cnt;
        wait_ibf(); hwr(3'd0, 8'h33); wait_ibf();
        peek(s);
        chk("R8 no strobe", re_cnt + we_cnt, c0);
        chk("R8 obf unchanged", s[0], 0);
    endtask

    task automatic t_unknown();
        logic [7:0] s;
        int c0 = re_cnt + we_cnt;
        wait_ibf(); hwr(3'd4, 8'h81);
        wait_ibf(); hwr(3'd4, 8'h99);
        wait_ibf(); hwr(3'd0, 8'h12);
        wait_ibf(); hwr(3'd0, 8'h34);
        wait_ibf();
        peek(s);
        chk("R9 no strobe", re_cnt + we_cnt, c0);
        chk("R9 obf", s[0], 0);
    endtask

    task automatic t_burst();
        logic [7:0] s;
        wait_ibf(); hwr(3'd4, 8'h82); wait_ibf();
        peek(s);
        chk("R10 burst on", s[4], 1);
        ec_wr(8'h05, 8'h66);
        peek(s);
        chk("R10 burst held", s[4], 1);
        wait_ibf(); hwr(3'd4, 8'h83); wait_ibf();
        peek(s);
        chk("R10 burst off", s[4], 0);
    endtask

    task automatic t_query();
        logic [7:0] v, s;
        mem[8'h00] = 8'hEE;
        wait_ibf(); hwr(3'd4, 8'h84);
        wait_obf();
        hrd(3'd0, v);
        chk("R11 query code", v, 8'h00);
        peek(s);
        chk("R11 obf drained", s[0], 0);
    endtask

    task automatic t_busy_drop();
        logic [7:0] s;
        int w0 = we_cnt;
        wait_ibf(); hwr(3'd4, 8'h81);
        hwr(3'd4, 8'h84);
        wait_ibf();
        peek(s);
        chk("R12 dropped query", s[0], 0);
        hwr(3'd0, 8'h40); wait_ibf();
        hwr(3'd0, 8'h77); wait_ibf();
        chk("R12 write intact", we_cnt, w0 + 1);
        chk("R12 mem", mem[8'h40], 8'h77);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        int w0 = we_cnt;
        wait_ibf(); hwr(3'd4, 8'h81);
        wait_ibf(); hwr(3'd0, 8'h20);
        ec_rd(8'h21, v);
        chk("R13 read value", v, 8'h21 ^ 8'h5A);
        chk("R13 no write", we_cnt, w0);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_ibf();
        t_write();
        t_read();
        t_status_keeps_obf();
        t_orphan();
        t_unknown();
        t_burst();
        t_query();
        t_busy_drop();
        t_restart();
        finish_up();
    end
endmodule